// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames on a single TX line. Each frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period. The frame format comes from an 8-bit line control word. Bit time is set by a 16x oversample enable, `tick`, which a baud-rate generator outside this block supplies.

A producer offers a byte on `data` with `valid`. The transmitter takes it in any cycle where `ready` is high. It samples the control word in that same cycle, so later edits to the word do not reach the frame in progress. One exception is the break bit, which acts on the line at once and overrides the framing. While break holds the line low, the frame sequencer keeps counting.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `ready` is 1. While idle and not in break, `txd` stays 1.
- R2: A frame begins with a start bit at 0. Every data bit and the parity bit lasts 16 `tick` pulses. Data bits go out least significant bit first.
- R3: `ctrl[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Data bits above that width are never sent.
- R4: With `ctrl[2]`=0 the stop period is one bit at 1, lasting 16 ticks. With `ctrl[2]`=1 it is 24 ticks for a 5-bit word and 32 ticks for 6, 7 or 8 bits.
- R5: With `ctrl[3]`=0 no parity bit is sent, and `ctrl[5:4]` has no effect.
- R6: With `ctrl[3]`=1, `ctrl[5:4]` picks the parity bit. 00 is odd and 01 is even, each counted over the configured data bits only. 10 sends a constant 1 and 11 sends a constant 0.
- R7: While `ctrl[6]`=1, `txd` is 0 in the same cycle. Frame timing keeps running during break, so `busy` falls on the same tick as it would without break.
- R8: `ctrl[7]` has no effect on the serial output.
- R9: The transmitter samples the control word (all bits except `ctrl[6]`) when it accepts a byte. Changing it mid-frame does not change the frame in progress.
- R10: `ready` equals not `busy`. A byte is accepted on a clock edge where `valid` and `ready` are both high. `busy` is high from the next cycle until the edge that follows the last stop tick. A new byte can be accepted in the first cycle of idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversample enable |
| ctrl | input | 8 | Line control word |
| data | input | 8 | Byte to send |
| valid | input | 1 | Byte offered |
| ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The hardest situation to reach from the ports is break raised and lowered in the middle of a frame. The hidden tick counter must keep advancing, and this is visible only in when `busy` falls and in which bit value reappears once break clears. The bench asserts break partway through a data bit and releases it several bit times later. It then compares every remaining tick against the original frame's per-tick expectations. A second stimulus flips every non-break control bit right after acceptance, which shows that the sampled format is the one used. The 24-tick stop period appears only with a 5-bit word and `ctrl[2]` set, so the bench sends that combination directly.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned OSR_DEF   = 16;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned CTRL_W    = 8;
    localparam int unsigned BIDX_W    = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD  = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ONE  = 2'b10,
        PAR_ZERO = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_len_e;

    typedef struct packed {
        logic [BIDX_W-1:0] last_idx;
        logic              par_en;
        par_mode_e         par_mode;
        stop_len_e         stop_len;
    } frame_fmt_t;

endpackage

// File: rtl/sertx_fmt_decode.sv
module sertx_fmt_decode
    import sertx_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output frame_fmt_t        fmt,
    output logic              brk
);

    logic unused_latch_sel;

    assign unused_latch_sel = ctrl[7];

    always_comb begin
        fmt.last_idx = BIDX_W'(4) + BIDX_W'(ctrl[1:0]);
        fmt.par_en   = ctrl[3];
        fmt.par_mode = par_mode_e'(ctrl[5:4]);
        if (!ctrl[2]) begin
            fmt.stop_len = STOP_ONE;
        end else if (ctrl[1:0] == 2'b00) begin
            fmt.stop_len = STOP_ONE_HALF;
        end else begin
            fmt.stop_len = STOP_TWO;
        end
        brk = ctrl[6];
    end

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
    import sertx_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]      data,
    input  logic [BIDX_W-1:0] last_idx,
    input  par_mode_e         mode,
    output logic              par_bit
);

    logic [W-1:0] keep;
    logic         xsum;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign keep[i] = data[i] & (BIDX_W'(i) <= last_idx);
    end

    assign xsum = ^keep;

    always_comb begin
        unique case (mode)
            PAR_ODD:  par_bit = ~xsum;
            PAR_EVEN: par_bit = xsum;
            PAR_ONE:  par_bit = 1'b1;
            default:  par_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int unsigned OSR = OSR_DEF,
    parameter int unsigned W   = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  frame_fmt_t   load_fmt,
    input  logic         load_par,
    output logic         line,
    output logic         idle
);

    localparam int unsigned CNT_W = $clog2(2 * OSR);
    localparam logic [CNT_W-1:0] LIM_BIT  = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OSR + OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OSR - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIDX_W-1:0] bidx;
        logic [W-1:0]      shreg;
        frame_fmt_t        fmt;
        logic              par;
        logic              line;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0] stop_lim;

    always_comb begin
        unique case (q.fmt.stop_len)
            STOP_ONE:      stop_lim = LIM_BIT;
            STOP_ONE_HALF: stop_lim = LIM_HALF;
            default:       stop_lim = LIM_TWO;
        endcase
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (load) begin
                    d.st    = ST_START;
                    d.cnt   = '0;
                    d.bidx  = '0;
                    d.shreg = load_data;
                    d.fmt   = load_fmt;
                    d.par   = load_par;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == LIM_BIT) begin
                        d.st  = ST_DATA;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == LIM_BIT) begin
                        d.cnt   = '0;
                        d.shreg = q.shreg >> 1;
                        if (q.bidx == q.fmt.last_idx) begin
                            d.st = q.fmt.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            d.bidx = q.bidx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (q.cnt == LIM_BIT) begin
                        d.st  = ST_STOP;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.cnt == stop_lim) begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        endcase

        unique case (d.st)
            ST_START: d.line = 1'b0;
            ST_DATA:  d.line = d.shreg[0];
            ST_PAR:   d.line = d.par;
            default:  d.line = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cnt   <= '0;
            q.bidx  <= '0;
            q.shreg <= '0;
            q.fmt   <= '0;
            q.par   <= 1'b0;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line = q.line;
    assign idle = (q.st == ST_IDLE);

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int unsigned OSR = OSR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              txd,
    output logic              busy
);

    frame_fmt_t fmt_now;
    logic       brk_now;
    logic       par_now;
    logic       seq_line;
    logic       seq_idle;
    logic       take;

    sertx_fmt_decode u_dec (
        .ctrl (ctrl),
        .fmt  (fmt_now),
        .brk  (brk_now)
    );

    sertx_parity #(.W(DATA_W)) u_par (
        .data     (data),
        .last_idx (fmt_now.last_idx),
        .mode     (fmt_now.par_mode),
        .par_bit  (par_now)
    );

    assign take = valid & seq_idle;

    sertx_seq #(.OSR(OSR), .W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (take),
        .load_data (data),
        .load_fmt  (fmt_now),
        .load_par  (par_now),
        .line      (seq_line),
        .idle      (seq_idle)
    );

    assign ready = seq_idle;
    assign busy  = ~seq_idle;
    assign txd   = seq_line & ~brk_now;

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [7:0] ctrl,
    input logic       valid,
    input logic       ready,
    input logic       txd,
    input logic       busy
);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl[6]) |-> txd);

    // R7
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[6] |-> !txd);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !ctrl[6]) |=> (ctrl[6] || $stable(txd)));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> busy);

    // R10
    end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    // R10
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready != busy);

endmodule

bind sertx_core sertx_core_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .ctrl  (ctrl),
    .valid (valid),
    .ready (ready),
    .txd   (txd),
    .busy  (busy)
);

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;

    typedef struct {
        logic  lvl;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] ctrl = 8'h03;
    logic [7:0] data = 8'h00;
    logic       valid = 1'b0;
    logic       ready, txd, busy;

    int   checks = 0;
    int   errors = 0;
    int   tdiv = 1;
    bit   done = 1'b0;
    exp_t q[$];

    sertx_core dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ctrl  (ctrl),
        .data  (data),
        .valid (valid),
        .ready (ready),
        .txd   (txd),
        .busy  (busy)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(posedge clk);
            #1;
            c = (c + 1 >= tdiv) ? 0 : c + 1;
            tick = (c == 0);
        end
    end

    // Monitor: one expected level per tick while a frame is in progress
    always @(negedge clk) begin
        if (rst_n && tick) begin
            if (busy) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 extra frame tick", int'(txd), -1);
                end else begin
                    exp_t e;
                    logic want;
                    e = q.pop_front();
                    want = ctrl[6] ? 1'b0 : e.lvl;
                    check(txd === want, ctrl[6] ? "R7" : e.tag, int'(txd), int'(want));
                end
            end else begin
                check(txd === !ctrl[6], "R1 idle level", int'(txd), int'(!ctrl[6]));
            end
        end
    end

    task automatic push_n(input logic lvl, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.lvl = lvl;
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [7:0] c, input bit chg);
        int   len;
        int   ones;
        logic p;
        len  = 5 + int'(c[1:0]);
        ones = 0;
        do @(negedge clk); while (!ready);
        ctrl  = c;
        data  = b;
        valid = 1'b1;
        push_n(1'b0, 16, "R2 start");
        for (int i = 0; i < len; i++) begin
            push_n(b[i], 16, "R3 data");
            ones += int'(b[i]);
        end
        if (c[3]) begin
            case (c[5:4])
                2'b00:   p = (ones % 2 == 0);
                2'b01:   p = (ones % 2 == 1);
                2'b10:   p = 1'b1;
                default: p = 1'b0;
            endcase
            push_n(p, 16, "R6 parity");
        end
        push_n(1'b1, c[2] ? ((len == 5) ? 24 : 32) : 16, "R4 stop");
        @(posedge clk);
        #1;
        valid = 1'b0;
        if (chg) ctrl = c ^ 8'hBF;   // R9: every non-break bit flipped mid-frame
        @(negedge clk);
        check(busy === 1'b1 && ready === 1'b0, "R10 accept", int'(busy), 1);
    endtask

    task automatic drain();
        do @(negedge clk); while (busy || q.size() != 0);
        check(q.size() == 0, "R4 frame length", q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(txd === 1'b1 && busy === 1'b0 && ready === 1'b1, "R1 reset", int'({txd, busy, ready}), 5);

        tdiv = 1;
        send(8'hA5, 8'h03, 1'b0);          // R2 R3: 8 bits, no parity, 1 stop
        drain();
        send(8'hF5, 8'h00, 1'b0);          // R3: 5 bits, upper bits unused
        drain();
        tdiv = 3;
        send(8'h2C, 8'h09, 1'b0);          // R6: 6 bits odd
        drain();
        send(8'hE0, 8'h08, 1'b0);          // R6: 5 bits odd over masked data
        drain();
        send(8'h5B, 8'h1E, 1'b0);          // R6 R4: 7 bits even, 2 stop
        drain();
        send(8'h11, 8'h2C, 1'b0);          // R4: 5 bits forced one, 1.5 stop
        drain();
        tdiv = 2;
        send(8'hFF, 8'h3F, 1'b0);          // R6 R4: 8 bits forced zero, 2 stop
        drain();
        send(8'h96, 8'h33, 1'b0);          // R5: parity off, mode bits set
        drain();
        send(8'h3C, 8'h8B, 1'b0);          // R8: top control bit set
        drain();
        send(8'h6D, 8'h1B, 1'b1);          // R9: control flipped mid-frame
        drain();

        // R10: back-to-back frames
        tdiv = 1;
        send(8'h81, 8'h03, 1'b0);
        send(8'h7E, 8'h0A, 1'b0);
        drain();

        // R7: break while idle acts at once
        ctrl = 8'h43;
        #1;
        check(txd === 1'b0, "R7 idle break", int'(txd), 0);
        ctrl = 8'h03;
        #1;
        check(txd === 1'b1, "R7 break release", int'(txd), 1);

        // R7: break raised mid-frame, timing keeps running
        tdiv = 2;
        send(8'hC3, 8'h03, 1'b0);
        repeat (40) @(negedge clk);
        ctrl = 8'h43;
        repeat (90) @(negedge clk);
        ctrl = 8'h03;
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule